// File: doc/BRIEF.md
# I2C Target Memory Controller

This block is an I2C bus target in front of a 1024-byte register-array memory. The memory is split into four pages of 256 bytes. The block runs on a fast system clock and oversamples the bus clock and data lines. It finds bus start and stop events in the sampled lines and decodes the first byte of each transfer as a device select. It then acknowledges the bytes it accepts by pulling the data line low during the ninth clock pulse. The only drive it puts on the bus is a pull-low enable for an open-drain pad.

A write transfer carries one byte of in-page offset and then a burst of data bytes. The data bytes go to consecutive offsets that wrap inside the selected page. Each accepted byte also appears as a one-cycle pulse on a write port that feeds the memory model. The number of data bytes one write transfer may store depends on the burst-mode input. A write-protect input blocks all stores. A read transfer streams bytes from the current offset for as long as the bus master acknowledges them. Only standard-speed bus timing is targeted.

Top module: `i2c_eeprom_target`

## Requirements
- R1: While `rst_n` is low and after it is released, `sda_pull` is 0 and `mem_we` is 0 until a transfer begins.
- R2: The first byte after a start is received most significant bit first. It is acknowledged only when bits 7..4 equal 4'b1010 and bit 3 equals `hw_addr`. A byte that does not match gets no acknowledge, and every later byte up to the next start or stop is neither acknowledged nor stored.
- R3: A falling data line while the clock line is high is a start. A rising data line while the clock line is high is a stop. A start received in the middle of a transfer (repeated start) restarts device-byte decoding, and a stop releases the data line.
- R4: In a write (device byte bit 0 = 0), bits 2..1 of the device byte select the page. The next byte is acknowledged and becomes the in-page offset. Each accepted data byte is stored at {page, offset}, shown as `mem_waddr` and `mem_wdata` with one `mem_we` pulse. The offset then increments modulo 256.
- R5: A write transfer accepts at most 7 data bytes when `page_mode` = 0 and at most 8 when `page_mode` = 1. Further data bytes are not acknowledged and cause no `mem_we`.
- R6: While `wprot` = 1, data bytes are not acknowledged and memory is unchanged. The device byte and the offset byte are still acknowledged.
- R7: In a read (device byte bit 0 = 1), bits 2..1 of the read device byte select the page. Bytes are sent most significant bit first, starting at the current offset, which increments modulo 256 after each byte. Sending continues while the master acknowledges.
- R8: After the master does not acknowledge a read byte, the target keeps the data line released until the next start or stop, even if more clock pulses follow.
- R9: `sda_pull` changes only while the clock line is low, and every `mem_we` pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock that oversamples the bus |
| rst_n | input | 1 | asynchronous active-low reset |
| scl_in | input | 1 | bus clock line level |
| sda_in | input | 1 | bus data line level (wired-AND of all drivers) |
| hw_addr | input | 1 | strap level compared with device byte bit 3 |
| wprot | input | 1 | active-high write protect |
| page_mode | input | 1 | 0 selects the 7-byte write limit, 1 the 8-byte limit |
| sda_pull | output | 1 | open-drain enable: 1 pulls the data line low |
| mem_we | output | 1 | one-cycle store strobe for the memory |
| mem_waddr | output | 10 | store address {page, offset} |
| mem_wdata | output | 8 | store data |

## Verification
A bit counter that is out of step moves the acknowledge into the wrong clock pulse. The master sees this at the ninth pulse of the very first byte. A bad device-byte decode or page field shows up as a missing acknowledge, or as a store to the wrong `mem_waddr` inside the same byte time. A wrong offset pointer or a wrong burst counter stays hidden inside one transfer: it shows as an extra or missing acknowledge on the eighth or ninth data byte, and as wrong data when the page is read back across the 255-to-0 wrap. A stuck read-continue flag shows as data bits pulled low after the master's not-acknowledge.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   localparam int EE_OFF_W  = 8;
   localparam int EE_SEL_W  = 2;
   localparam int EE_ADDR_W = EE_OFF_W + EE_SEL_W;
   localparam int EE_BYTE_W = 8;
   localparam int EE_BIT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADR,
      ST_WDAT,
      ST_RDAT,
      ST_SKIP
   } ee_state_e;

   typedef struct packed {
      logic scl;
      logic sda;
      logic rise;
      logic fall;
      logic start;
      logic stop;
   } bus_evt_t;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_ee_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_lvl   = scl_pipe[STAGES-1];
   assign sda_lvl   = sda_pipe[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_q;
   assign scl_fall  = ~scl_lvl & scl_q;
   assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 8,
   parameter bit RESET_MEM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_depth
         $error("i2c_ee_mem: ADDR_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (RESET_MEM) begin : g_cleared
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (we) begin
               cells[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         logic rst_seen;
         always_ff @(posedge clk) begin
            rst_seen <= rst_n;
            if (we) cells[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
   import i2c_ee_pkg::*;
#(
   parameter logic [3:0] DEV_CODE     = 4'b1010,
   parameter int         LIMIT_NORMAL = 7,
   parameter int         LIMIT_PAGE   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  bus_evt_t             evt,
   input  logic                 hw_addr,
   input  logic                 wprot,
   input  logic                 page_mode,
   input  logic [EE_BYTE_W-1:0] rd_data,
   output logic [EE_ADDR_W-1:0] rd_addr,
   output logic                 sda_pull,
   output logic                 mem_we,
   output logic [EE_ADDR_W-1:0] mem_waddr,
   output logic [EE_BYTE_W-1:0] mem_wdata
);

   localparam int                  CNT_W     = $clog2(LIMIT_PAGE + 1);
   localparam logic [CNT_W-1:0]    LIM_N     = CNT_W'(LIMIT_NORMAL);
   localparam logic [CNT_W-1:0]    LIM_P     = CNT_W'(LIMIT_PAGE);
   localparam logic [EE_BIT_W-1:0] BIT_BYTE  = EE_BIT_W'(EE_BYTE_W);
   localparam logic [EE_BIT_W-1:0] BIT_ACK   = EE_BIT_W'(EE_BYTE_W + 1);

   ee_state_e              state;
   logic [EE_BIT_W-1:0]    bitcnt;
   logic [EE_BYTE_W-1:0]   shreg;
   logic [EE_BYTE_W-1:0]   txreg;
   logic [EE_SEL_W-1:0]    page;
   logic [EE_OFF_W-1:0]    ptr;
   logic [CNT_W-1:0]       wcnt;
   logic                   cont;
   logic                   pull;
   logic                   we_q;
   logic [EE_ADDR_W-1:0]   waddr_q;
   logic [EE_BYTE_W-1:0]   wdata_q;

   logic [CNT_W-1:0]       limit;
   logic                   dev_hit;
   logic                   wr_ok;

   assign limit   = page_mode ? LIM_P : LIM_N;
   assign dev_hit = (shreg[7:4] == DEV_CODE) && (shreg[3] == hw_addr);
   assign wr_ok   = (wcnt < limit) && !wprot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         txreg   <= '0;
         page    <= '0;
         ptr     <= '0;
         wcnt    <= '0;
         cont    <= 1'b0;
         pull    <= 1'b0;
         we_q    <= 1'b0;
         waddr_q <= '0;
         wdata_q <= '0;
      end else begin
         we_q <= 1'b0;
         if (evt.start) begin
            state  <= ST_DEV;
            bitcnt <= '0;
            pull   <= 1'b0;
            wcnt   <= '0;
         end else if (evt.stop) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            pull   <= 1'b0;
         end else if (state != ST_IDLE) begin
            if (evt.rise) begin
               if (bitcnt != BIT_ACK) bitcnt <= bitcnt + 1'b1;
               if (bitcnt < BIT_BYTE) shreg <= {shreg[EE_BYTE_W-2:0], evt.sda};
               if (bitcnt == BIT_BYTE && state == ST_RDAT) cont <= ~evt.sda;
            end else if (evt.fall && !evt.scl) begin
               if (bitcnt == BIT_BYTE) begin
                  case (state)
                     ST_DEV: begin
                        if (dev_hit) begin
                           pull <= 1'b1;
                           page <= shreg[EE_SEL_W:1];
                           if (shreg[0]) begin
                              state <= ST_RDAT;
                              cont  <= 1'b1;
                           end else begin
                              state <= ST_WADR;
                           end
                        end else begin
                           pull  <= 1'b0;
                           state <= ST_SKIP;
                        end
                     end
                     ST_WADR: begin
                        pull  <= 1'b1;
                        ptr   <= shreg[EE_OFF_W-1:0];
                        state <= ST_WDAT;
                     end
                     ST_WDAT: begin
                        if (wr_ok) begin
                           pull    <= 1'b1;
                           we_q    <= 1'b1;
                           waddr_q <= {page, ptr};
                           wdata_q <= shreg;
                           ptr     <= ptr + 1'b1;
                           wcnt    <= wcnt + 1'b1;
                        end else begin
                           pull <= 1'b0;
                        end
                     end
                     ST_RDAT: begin
                        pull <= 1'b0;
                        ptr  <= ptr + 1'b1;
                     end
                     default: pull <= 1'b0;
                  endcase
               end else if (bitcnt == BIT_ACK) begin
                  bitcnt <= '0;
                  if (state == ST_RDAT) begin
                     if (cont) begin
                        txreg <= rd_data;
                        pull  <= ~rd_data[EE_BYTE_W-1];
                     end else begin
                        state <= ST_SKIP;
                        pull  <= 1'b0;
                     end
                  end else begin
                     pull <= 1'b0;
                  end
               end else if (bitcnt != '0 && state == ST_RDAT) begin
                  pull  <= ~txreg[EE_BYTE_W-2];
                  txreg <= {txreg[EE_BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign rd_addr   = {page, ptr};
   assign sda_pull  = pull;
   assign mem_we    = we_q;
   assign mem_waddr = waddr_q;
   assign mem_wdata = wdata_q;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
   import i2c_ee_pkg::*;
#(
   parameter int         SYNC_STAGES  = 2,
   parameter logic [3:0] DEV_CODE     = 4'b1010,
   parameter int         LIMIT_NORMAL = 7,
   parameter int         LIMIT_PAGE   = 8,
   parameter bit         RESET_MEM    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_in,
   input  logic                 sda_in,
   input  logic                 hw_addr,
   input  logic                 wprot,
   input  logic                 page_mode,
   output logic                 sda_pull,
   output logic                 mem_we,
   output logic [EE_ADDR_W-1:0] mem_waddr,
   output logic [EE_BYTE_W-1:0] mem_wdata
);

   generate
      if (LIMIT_NORMAL < 1 || LIMIT_PAGE < LIMIT_NORMAL || LIMIT_PAGE > 255) begin : g_bad_limits
         $error("i2c_eeprom_target: burst limits out of range");
      end
   endgenerate

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   bus_evt_t             evt;
   logic [EE_ADDR_W-1:0] rd_addr;
   logic [EE_BYTE_W-1:0] rd_data;

   i2c_ee_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   assign evt = '{scl: scl_lvl, sda: sda_lvl, rise: scl_rise, fall: scl_fall,
                  start: start_det, stop: stop_det};

   i2c_ee_ctrl #(
      .DEV_CODE     (DEV_CODE),
      .LIMIT_NORMAL (LIMIT_NORMAL),
      .LIMIT_PAGE   (LIMIT_PAGE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .hw_addr   (hw_addr),
      .wprot     (wprot),
      .page_mode (page_mode),
      .rd_data   (rd_data),
      .rd_addr   (rd_addr),
      .sda_pull  (sda_pull),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata)
   );

   i2c_ee_mem #(
      .ADDR_W    (EE_ADDR_W),
      .DATA_W    (EE_BYTE_W),
      .RESET_MEM (RESET_MEM)
   ) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker #(
   parameter int LIMIT_NORMAL = 7,
   parameter int LIMIT_PAGE   = 8
) (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_det,
   input logic stop_det,
   input logic sda_pull,
   input logic mem_we,
   input logic wprot,
   input logic page_mode
);

   localparam logic [7:0] CAP_N = 8'(LIMIT_NORMAL);
   localparam logic [7:0] CAP_P = 8'(LIMIT_PAGE);

   logic [7:0] burst_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) burst_cnt <= '0;
      else if (start_det || stop_det) burst_cnt <= '0;
      else if (mem_we && burst_cnt != 8'hFF) burst_cnt <= burst_cnt + 1'b1;
   end

   AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s);                                   // R9
   AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);                                              // R9
   AST_WE_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !$past(wprot));                                        // R6
   AST_BURST_CAP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_cnt <= CAP_P);                                              // R5
   AST_BURST_CAP_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      !page_mode |-> burst_cnt <= CAP_N);                               // R5
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull);                                          // R3

endmodule

bind i2c_eeprom_target i2c_ee_checker #(
   .LIMIT_NORMAL (LIMIT_NORMAL),
   .LIMIT_PAGE   (LIMIT_PAGE)
) u_i2c_ee_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_lvl),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_pull  (sda_pull),
   .mem_we    (mem_we),
   .wprot     (wprot),
   .page_mode (page_mode)
);

// File: tb/i2c_eeprom_target_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_target_bench;

   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic m_scl, m_sda;
   logic hw_addr, wprot, page_mode;
   logic sda_pull, mem_we;
   logic [9:0] mem_waddr;
   logic [7:0] mem_wdata;
   wire  sda_line = m_sda & ~sda_pull;

   always #4 clk = ~clk;

   i2c_eeprom_target u_i2c_eeprom_target (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (m_scl),
      .sda_in    (sda_line),
      .hw_addr   (hw_addr),
      .wprot     (wprot),
      .page_mode (page_mode),
      .sda_pull  (sda_pull),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata)
   );

   int checks = 0;
   int errors = 0;
   int we_cnt = 0;
   int pull_bad = 0;
   int we_bad = 0;
   bit done = 0;
   logic prev_pull = 1'b0;
   logic prev_we = 1'b0;
   logic [9:0] last_waddr = '0;
   logic [7:0] last_wdata = '0;
   logic [7:0] exp_mem [1024];

   always @(posedge clk) begin
      prev_pull <= sda_pull;
      prev_we   <= mem_we;
      if (rst_n && (sda_pull != prev_pull) && m_scl) pull_bad <= pull_bad + 1;
      if (mem_we && prev_we) we_bad <= we_bad + 1;
      if (mem_we) begin
         we_cnt     <= we_cnt + 1;
         last_waddr <= mem_waddr;
         last_wdata <= mem_wdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_scl = 1'b0; qwait();
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b0; qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      m_scl = 1'b0; qwait();
      m_sda = 1'b0; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b1; qwait(); qwait();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qwait();
         m_scl = 1'b1; qwait(); qwait();
         m_scl = 1'b0; qwait();
      end
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      ack = (sda_line == 1'b0);
      qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit give_ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = 1'b1; qwait();
         m_scl = 1'b1; qwait();
         b[i] = sda_line;
         qwait();
         m_scl = 1'b0; qwait();
      end
      m_sda = give_ack ? 1'b0 : 1'b1; qwait();
      m_scl = 1'b1; qwait(); qwait();
      m_scl = 1'b0; qwait();
   endtask

   function automatic logic [7:0] dev_byte(input logic hw, input int pg, input logic rd);
      logic [1:0] p2 = 2'(pg);
      return {4'b1010, hw, p2, rd};
   endfunction

   // set offset with a write header, then repeated start and read n bytes
   task automatic read_burst(input int wpg, input logic [7:0] off, input int n,
                             input int rpg, input string tag, input bit extra);
      bit ack;
      logic [7:0] d;
      logic [7:0] o;
      logic [9:0] a;
      bus_start();
      send_byte(dev_byte(hw_addr, wpg, 1'b0), ack);
      chk(ack, "R4 write header ack", ack, 1);
      send_byte(off, ack);
      chk(ack, "R4 offset ack", ack, 1);
      bus_start();
      send_byte(dev_byte(hw_addr, rpg, 1'b1), ack);
      chk(ack, "R3 repeated start device ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(d, i < n - 1);
         o = 8'(int'(off) + i);
         a = {2'(rpg), o};
         chk(d == exp_mem[a], tag, d, exp_mem[a]);
      end
      if (extra) begin
         recv_byte(d, 1'b0);
         chk(d == 8'hFF, "R8 released after nack", d, 8'hFF);
         chk(sda_pull == 1'b0, "R8 pull idle", sda_pull, 0);
      end
      bus_stop();
   endtask

   initial begin
      bit ack, hit, exp_ack;
      logic [7:0] b, d, s;
      int n0;
      rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
      hw_addr = 1'b0; wprot = 1'b0; page_mode = 1'b0;
      for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
      repeat (10) @(negedge clk);
      chk(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
      chk(mem_we == 1'b0, "R1 we in reset", mem_we, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
      chk(mem_we == 1'b0, "R1 we after reset", mem_we, 0);

      // R2: sweep upper five bits of the device byte against both strap levels
      for (int h = 0; h < 2; h++) begin
         for (int u = 0; u < 32; u++) begin
            hw_addr = h[0];
            b   = {u[4:0], 3'b000};
            hit = (u[4:1] == 4'b1010) && (u[0] == h[0]);
            n0  = we_cnt;
            bus_start();
            send_byte(b, ack);
            chk(ack == hit, "R2 device byte ack", ack, hit);
            send_byte(8'h00, ack);
            chk(ack == hit, "R2 offset after select", ack, hit);
            send_byte(8'h5A, ack);
            chk(ack == hit, "R2 data after select", ack, hit);
            chk(we_cnt == n0 + (hit ? 1 : 0), "R2 store count", we_cnt, n0 + (hit ? 1 : 0));
            bus_stop();
            if (hit) exp_mem[0] = 8'h5A;
         end
      end

      // R4 / R5: bursts of nine data bytes across the page wrap, both modes, all pages
      hw_addr = 1'b1;
      for (int m = 0; m < 2; m++) begin
         for (int p = 0; p < 4; p++) begin
            page_mode = m[0];
            s = 8'(8'hFB + p);
            bus_start();
            send_byte(dev_byte(1'b1, p, 1'b0), ack);
            chk(ack, "R4 device ack", ack, 1);
            send_byte(s, ack);
            chk(ack, "R4 offset ack", ack, 1);
            for (int i = 0; i < 9; i++) begin
               d = 8'(p * 37 + i * 11 + m * 101);
               n0 = we_cnt;
               send_byte(d, ack);
               exp_ack = (i < (m == 1 ? 8 : 7));
               chk(ack == exp_ack, "R5 data ack vs limit", ack, exp_ack);
               if (exp_ack) begin
                  chk(we_cnt == n0 + 1, "R4 one store", we_cnt, n0 + 1);
                  chk(last_waddr == {2'(p), 8'(int'(s) + i)}, "R4 store address wrap",
                      last_waddr, {2'(p), 8'(int'(s) + i)});
                  chk(last_wdata == d, "R4 store data", last_wdata, d);
                  exp_mem[{2'(p), 8'(int'(s) + i)}] = d;
               end else begin
                  chk(we_cnt == n0, "R5 no store past limit", we_cnt, n0);
               end
            end
            bus_stop();
         end
      end

      // R6: protected write
      page_mode = 1'b0;
      wprot = 1'b1;
      n0 = we_cnt;
      bus_start();
      send_byte(dev_byte(1'b1, 3, 1'b0), ack);
      chk(ack, "R6 device ack while protected", ack, 1);
      send_byte(8'h10, ack);
      chk(ack, "R6 offset ack while protected", ack, 1);
      for (int i = 0; i < 3; i++) begin
         send_byte(8'(8'hC3 + i), ack);
         chk(!ack, "R6 data nack while protected", ack, 0);
      end
      chk(we_cnt == n0, "R6 no store while protected", we_cnt, n0);
      bus_stop();
      wprot = 1'b0;
      read_burst(3, 8'h0F, 5, 3, "R6 protected bytes unchanged", 1'b0);

      // R7 / R8: read back every page across the wrap, then cross-page and release
      for (int p = 0; p < 4; p++) read_burst(p, 8'hF8, 12, p, "R7 read data", 1'b0);
      read_burst(0, 8'h00, 2, 0, "R2 selected store read back", 1'b0);
      read_burst(1, 8'hFD, 5, 2, "R7 read page from read header", 1'b1);

      chk(pull_bad == 0, "R9 pull changed with clock high", pull_bad, 0);
      chk(we_bad == 0, "R9 store strobe longer than one cycle", we_bad, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule